// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timing Unit

This block generates three complementary pairs of gate-drive signals for a three-phase power stage. An internal counter runs up for the first half of each switching period and back down for the second half, so every switching edge sits at the same distance from the period midpoint. Each channel has a duty value that sets the high-side on-time. A shared dead-time value moves both edges of each high/low pair away from the duty-defined instant, so the two devices of a leg are never on together. All six outputs are active low: a low level turns the associated power device on.

Software programs the period, dead time, sync pulse width, update mode and three duty values through a simple write port. Writes land in shadow registers. The shadow set is copied to the active set at every period start. In double update mode it is also copied at the midpoint, so the second half can use a different period, dead time and duty. A sync pulse marks every reload boundary, and a half-cycle flag shows which half of the period is running. The enable input stops the unit, holds the counter at its start and parks all outputs at the inactive level.

Top module: `pwm3_center`

## Requirements
- R1: Writes set shadow registers at the addresses 0 = period, 1 = dead time, 2 = sync width, 3 = mode (bit 0 set selects double update), 4 + k = duty of channel k (k = 0..2). A new period, dead time, sync width or duty has no effect on the outputs until the next reload boundary.
- R2: With active half length H (period / 2, rounded down, minimum 1), half_o is low for the first H cycles of a period and high for the next H cycles.
- R3: Over one period in single update mode, pwm_hi_no[k] is low for 2 x (duty_k - dead) cycles, saturated to the range 0..2H.
- R4: Over one period in single update mode, pwm_lo_no[k] is low for 2H - 2 x (duty_k + dead) cycles, saturated to the range 0..2H.
- R5: pwm_hi_no[k] and pwm_lo_no[k] are never low in the same cycle.
- R6: In single update mode, each output waveform is symmetric about the period midpoint: cycle i matches cycle 2H-1-i.
- R7: In double update mode, period and duty values written during the first half take effect for the second half. The second half then lasts the new H, and its high-side on-time is duty - dead for that half.
- R8: sync_o goes high in the first cycle of every period, and also in the first cycle of the second half in double update mode. It stays high for sync width + 1 cycles.
- R9: While en_i is low, all six outputs are high, sync_o is low and the counter is held at its start (half_o low one cycle later). The first enabled cycle starts a new period with a sync pulse.
- R10: A write presented in the same cycle as a reload is taken by that reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low parks outputs and counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| pwm_hi_no | output | 3 | High-side gate commands, active low |
| pwm_lo_no | output | 3 | Low-side gate commands, active low |
| sync_o | output | 1 | Reload boundary pulse |
| half_o | output | 1 | Low in first half, high in second half |

## Verification
A register write and a reload can fall in the same cycle. The bench provokes this by writing a duty value during the last cycle of a period, and again by writing period and duty just before the midpoint in double update mode. It then checks that the very next period or half uses the new value, measured as low-level cycle counts on the outputs. The other corner cases are covered by table-driven runs: duty below dead time, duty at or beyond the half period, and zero dead time. Each is compared against on-times computed from the saturation formulas.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned CH_N      = 3;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned DUTY_BASE = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 3'd0,
    A_DEAD   = 3'd1,
    A_SYNC   = 3'd2,
    A_MODE   = 3'd3
  } reg_addr_e;

  typedef struct packed {
    logic [CNT_W-1:0]           half;
    logic [CNT_W-1:0]           dead;
    logic [CNT_W-1:0]           sync_w;
    logic [CH_N-1:0][CNT_W-1:0] duty;
  } timing_t;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              load_i,
  output timing_t           act_o,
  output timing_t           nxt_o,
  output logic              dbl_o
);
  logic [CNT_W-1:0] period_q, dead_q, sync_q;
  logic [CH_N-1:0][CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] period_d;
  logic dbl_q;
  timing_t act_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wr_en_i && (wr_addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      dead_q   <= '0;
      sync_q   <= '0;
      dbl_q    <= 1'b0;
    end else begin
      if (hit(A_PERIOD)) period_q <= wr_data_i;
      if (hit(A_DEAD))   dead_q   <= wr_data_i;
      if (hit(A_SYNC))   sync_q   <= wr_data_i;
      if (hit(A_MODE))   dbl_q    <= wr_data_i[0];
    end
  end

  // shadow values including a write landing this cycle (forwarded to reload)
  assign period_d = hit(A_PERIOD) ? wr_data_i : period_q;

  always_comb begin
    nxt_o.half   = (period_d < CNT_W'(2)) ? CNT_W'(1) : (period_d >> 1);
    nxt_o.dead   = hit(A_DEAD) ? wr_data_i : dead_q;
    nxt_o.sync_w = hit(A_SYNC) ? wr_data_i : sync_q;
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_duty
    localparam logic [ADDR_W-1:0] ADDR_C = ADDR_W'(DUTY_BASE + c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          duty_q[c] <= '0;
      else if (hit(ADDR_C)) duty_q[c] <= wr_data_i;
    end
    assign nxt_o.duty[c] = hit(ADDR_C) ? wr_data_i : duty_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= '0;
      act_q.half <= CNT_W'(1);
    end else if (!en_i || load_i) begin
      act_q <= nxt_o;
    end
  end

  assign act_o = act_q;
  assign dbl_o = dbl_q;
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dbl_i,
  input  logic [CNT_W-1:0] half_act_i,
  input  logic [CNT_W-1:0] half_nxt_i,
  input  logic [CNT_W-1:0] sync_nxt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             half_o,
  output logic             load_o,
  output logic             sync_o
);
  localparam int unsigned SL_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic [SL_W-1:0]  sync_left_q;
  logic             end_first, end_period;

  assign end_first  = !half_q && (cnt_q == half_act_i - CNT_W'(1));
  assign end_period =  half_q && (cnt_q == '0);
  assign load_o     = en_i && (end_period || (dbl_i && end_first));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!en_i || end_period) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (end_first) begin
      half_q <= 1'b1;
      if (dbl_i) cnt_q <= half_nxt_i - CNT_W'(1);
    end else if (!half_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sync_left_q <= '0;
    else if (!en_i || load_o)     sync_left_q <= SL_W'(sync_nxt_i) + SL_W'(1);
    else if (sync_left_q != '0)   sync_left_q <= sync_left_q - SL_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign half_o = half_q;
  assign sync_o = en_i && (sync_left_q != '0);
endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel
  import pwm3_pkg::*;
(
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             hi_no,
  output logic             lo_no
);
  localparam int unsigned W2 = CNT_W + 2;

  logic [W2-1:0] h, d, dt, hi_sum, lo_sum, th_hi, th_lo, cnt_w;

  always_comb begin
    h      = W2'(half_i);
    d      = W2'(duty_i);
    dt     = W2'(dead_i);
    cnt_w  = W2'(cnt_i);
    hi_sum = h + dt;
    lo_sum = d + dt;
    // thresholds clamped to 0..half so on-times saturate
    if (hi_sum <= d)           th_hi = '0;
    else if (hi_sum - d >= h)  th_hi = h;
    else                       th_hi = hi_sum - d;
    th_lo = (lo_sum >= h) ? '0 : (h - lo_sum);
    hi_no = !(en_i && (cnt_w >= th_hi));
    lo_no = !(en_i && (cnt_w <  th_lo));
  end
endmodule

// File: rtl/pwm3_center.sv
module pwm3_center
  import pwm3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CH_N-1:0]   pwm_hi_no,
  output logic [CH_N-1:0]   pwm_lo_no,
  output logic              sync_o,
  output logic              half_o
);
  timing_t          act, nxt;
  logic             dbl, load;
  logic [CNT_W-1:0] cnt;

  pwm3_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .act_o     (act),
    .nxt_o     (nxt),
    .dbl_o     (dbl)
  );

  pwm3_timebase u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .dbl_i      (dbl),
    .half_act_i (act.half),
    .half_nxt_i (nxt.half),
    .sync_nxt_i (nxt.sync_w),
    .cnt_o      (cnt),
    .half_o     (half_o),
    .load_o     (load),
    .sync_o     (sync_o)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm3_channel u_ch (
      .en_i   (en_i),
      .cnt_i  (cnt),
      .half_i (act.half),
      .duty_i (act.duty[c]),
      .dead_i (act.dead),
      .hi_no  (pwm_hi_no[c]),
      .lo_no  (pwm_lo_no[c])
    );
  end
endmodule

// File: rtl/pwm3_checker.sv
module pwm3_checker
  import pwm3_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [CH_N-1:0] pwm_hi_no,
  input logic [CH_N-1:0] pwm_lo_no,
  input logic            sync_o,
  input logic            half_o
);
  assert_idle_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ((&pwm_hi_no) && (&pwm_lo_no) && !sync_o));

  assert_counter_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !half_o);

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &(pwm_hi_no | pwm_lo_no));

  assert_sync_on_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $rose(sync_o)) |-> (half_o != $past(half_o)));

  assert_sync_at_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $fell(half_o)) |-> sync_o);
endmodule

bind pwm3_center pwm3_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .pwm_hi_no (pwm_hi_no),
  .pwm_lo_no (pwm_lo_no),
  .sync_o    (sync_o),
  .half_o    (half_o)
);

// File: tb/test_pwm3_center.sv
module test_pwm3_center;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  hi_n, lo_n;
  logic        sync, half;

  int total = 0, bad = 0;
  int hi_cnt[3], lo_cnt[3];
  int sync_cnt, half_cnt;
  logic [255:0] pat_hi, pat_lo;
  bit done = 0;

  // P, d0, d1, d2, dead, sync width
  localparam int VEC[3][6] = '{
    '{20, 5,  3,  0, 1, 0},
    '{16, 8, 10,  2, 0, 2},
    '{30, 7,  1, 14, 2, 3}
  };

  always #5 clk = ~clk;

  pwm3_center i_pwm3_center (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pwm_hi_no(hi_n), .pwm_lo_no(lo_n), .sync_o(sync), .half_o(half)
  );

  function automatic int clampp(int v, int p);
    if (v < 0) return 0;
    if (v > p) return p;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_addr = 3'(a); wr_data = 16'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_counts();
    for (int c = 0; c < 3; c++) begin hi_cnt[c] = 0; lo_cnt[c] = 0; end
    sync_cnt = 0; half_cnt = 0; pat_hi = '1; pat_lo = '1;
  endtask

  // called right after a negedge; optional write driven in cycle wk
  task automatic run(int n, int wk, int a, int d);
    for (int i = 0; i < n; i++) begin
      if (i == wk) begin wr_addr = 3'(a); wr_data = 16'(d); wr_en = 1'b1; end
      else wr_en = 1'b0;
      #1;
      for (int c = 0; c < 3; c++) begin
        if (!hi_n[c]) hi_cnt[c]++;
        if (!lo_n[c]) lo_cnt[c]++;
      end
      if (sync) sync_cnt++;
      if (half) half_cnt++;
      pat_hi[i] = hi_n[0];
      pat_lo[i] = lo_n[0];
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    // reset state (R9)
    #2;
    chk("R9 reset hi", int'(hi_n), 7);
    chk("R9 reset lo", int'(lo_n), 7);
    chk("R9 reset sync", int'(sync), 0);
    chk("R2 reset half", int'(half), 0);
    #30 rst_ni = 1'b1;
    @(negedge clk);

    // table-driven single update runs (R2 R3 R4 R6 R8 R9)
    for (int v = 0; v < 3; v++) begin
      int p, dt, sw;
      int sym;
      p = VEC[v][0]; dt = VEC[v][4]; sw = VEC[v][5];
      wr(0, p); wr(1, dt); wr(2, sw); wr(3, 0);
      for (int c = 0; c < 3; c++) wr(4 + c, VEC[v][1 + c]);
      en = 1'b1;
      clear_counts();
      run(p, -1, 0, 0);
      for (int c = 0; c < 3; c++) begin
        chk("R3 high on-time", hi_cnt[c], clampp(2 * (VEC[v][1 + c] - dt), p));
        chk("R4 low on-time", lo_cnt[c], clampp(p - 2 * (VEC[v][1 + c] + dt), p));
      end
      chk("R8 sync width", sync_cnt, sw + 1);
      chk("R2 half length", half_cnt, p / 2);
      sym = 1;
      for (int i = 0; i < p; i++)
        if (pat_hi[i] != pat_hi[p - 1 - i] || pat_lo[i] != pat_lo[p - 1 - i]) sym = 0;
      chk("R6 symmetry", sym, 1);
      en = 1'b0;
      #1;
      chk("R9 disabled outputs", int'({hi_n, lo_n, sync}), 7'h7e);
      @(negedge clk);
      chk("R9 counter held", int'(half), 0);
    end

    // shadow: mid-period write waits for next period (R1)
    wr(0, 20); wr(1, 1); wr(2, 0); wr(4, 5);
    en = 1'b1;
    clear_counts(); run(20, 3, 4, 2);
    chk("R1 duty write deferred", hi_cnt[0], 8);
    clear_counts(); run(20, -1, 0, 0);
    chk("R1 duty applied next period", hi_cnt[0], 2);

    // write in the reload cycle (R10)
    clear_counts(); run(20, 19, 4, 4);
    chk("R10 current period unchanged", hi_cnt[0], 2);
    chk("R8 one sync per single period", sync_cnt, 1);
    clear_counts(); run(20, -1, 0, 0);
    chk("R10 reload takes same-cycle write", hi_cnt[0], 6);

    // double update (R7 R8)
    en = 1'b0;
    @(negedge clk);
    wr(3, 1); wr(0, 20); wr(1, 0); wr(4, 5);
    en = 1'b1;
    clear_counts();
    run(1, -1, 0, 0);
    run(1, 0, 4, 2);
    run(8, 7, 0, 12);
    chk("R7 first half high on-time", hi_cnt[0], 5);
    chk("R8 sync at period start", sync_cnt, 1);
    chk("R2 first half flag low", half_cnt, 0);
    clear_counts(); run(6, -1, 0, 0);
    chk("R7 second half high on-time", hi_cnt[0], 2);
    chk("R7 second half length", half_cnt, 6);
    chk("R8 sync at midpoint", sync_cnt, 1);
    clear_counts(); run(1, -1, 0, 0);
    chk("R2 new period starts low", half_cnt, 0);
    chk("R8 sync at next start", sync_cnt, 1);

    done = 1;
    report();
  end
endmodule